// File: doc/BRIEF.md
# Exception Priority Resolver

This block sits beside the execution pipeline of a small processor core. It gathers every pending exception source and each cycle selects the single one to service. For that exception it presents the vector number and the byte address of its slot in the vector table. Sources fall into three timing classes:

- **Faults** act immediately and cancel the instruction in flight.
- **Completion-time events** are only considered in the cycle an instruction retires.
- **Execution traps** come from the instruction itself.

External interrupt requests arrive on an active-low three-pin level bus. Each request is filtered against the interrupt mask held in the status register.

Sources are sampled on the clock edge. The winner is registered and held until the consumer (the stacking sequencer) acknowledges it with an accept strobe. While a request is held, only a fault of strictly higher priority may replace it.

Top module: `exc_resolver`

## Requirements
- R1: While rst_ni is low, and after its release until a source is sampled, exc_valid_o and exc_abort_o are 0.
- R2: Fault class, highest first: reset request (vector 0), bus fault (vector 2), alignment fault (vector 3). Each sets exc_abort_o to 1 and is taken whether or not insn_done_i is high.
- R3: Trace, interrupt, illegal opcode, both emulation classes and privilege violation are considered only in a cycle where insn_done_i is 1.
- R4: Completion-time order, highest first: trace when sr_trace_i is 1 (vector 9), accepted interrupt, illegal opcode (vector 4), opcode class hex A (vector 10), opcode class hex F (vector 11), privilege violation (vector 8).
- R5: The interrupt level is the bitwise inverse of irq_n_i, and level 0 is no request. A level L is accepted when L > irq_mask_i or when L = 7. An accepted level gives vector 24+L; an unaccepted one has no effect on the outputs.
- R6: Execution traps rank below both other classes and are considered in any cycle. Their order, highest first: software trap (vector 32+trap_num_i), overflow (vector 7), bounds check (vector 6), divide by zero (vector 5).
- R7: exc_addr_o equals exc_vec_o multiplied by four.
- R8: A source present before a rising edge is reflected on the outputs right after that edge, and not before it.
- R9: While exc_valid_o is 1 and accept_i is 0, the held vector does not change unless a higher-priority fault arrives. A cycle with accept_i high loads that cycle's winner, or clears exc_valid_o if nothing is pending.
- R10: A fault of strictly higher priority than the held request replaces it on the next edge. exc_abort_o is 1 only for vectors 0, 2 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reset_req_i | input | 1 | Hard reset exception request |
| bus_fault_i | input | 1 | Bus fault |
| align_fault_i | input | 1 | Alignment fault |
| insn_done_i | input | 1 | Current instruction completes this cycle |
| sr_trace_i | input | 1 | Trace bit of the status register |
| irq_n_i | input | 3 | Encoded interrupt level, active low |
| irq_mask_i | input | 3 | Interrupt mask from the status register |
| illegal_i | input | 1 | Illegal opcode |
| emu_a_i | input | 1 | Opcode in the hex A emulation class |
| emu_f_i | input | 1 | Opcode in the hex F emulation class |
| priv_viol_i | input | 1 | Privilege violation |
| trap_i | input | 1 | Software trap instruction |
| trap_num_i | input | 4 | Software trap number |
| ovf_trap_i | input | 1 | Trap on overflow taken |
| bounds_trap_i | input | 1 | Bounds check failed |
| div_zero_i | input | 1 | Divide by zero |
| accept_i | input | 1 | Consumer takes the held exception |
| exc_valid_o | output | 1 | An exception is held |
| exc_vec_o | output | 8 | Vector number |
| exc_addr_o | output | 10 | Vector table byte address |
| exc_abort_o | output | 1 | Held exception cancels the current instruction |

## Verification
A wrong priority chain or a wrong interrupt gate shows up on exc_vec_o one edge after the offending input pattern, so the sweeps compare every cycle directly against an arithmetic model. A corrupted hold register instead shows as a vector changing while accept_i is low, or as a fault that fails to pre-empt. Directed sequences catch these within two or three cycles. A stale address register appears as an exc_addr_o that is not four times the vector.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int EXC_VEC_W  = 8;
  localparam int EXC_RANK_W = 4;

  localparam logic [EXC_VEC_W-1:0] VEC_RESET   = 8'd0;
  localparam logic [EXC_VEC_W-1:0] VEC_BUS     = 8'd2;
  localparam logic [EXC_VEC_W-1:0] VEC_ALIGN   = 8'd3;
  localparam logic [EXC_VEC_W-1:0] VEC_ILLEGAL = 8'd4;
  localparam logic [EXC_VEC_W-1:0] VEC_DIVZ    = 8'd5;
  localparam logic [EXC_VEC_W-1:0] VEC_BOUNDS  = 8'd6;
  localparam logic [EXC_VEC_W-1:0] VEC_OVF     = 8'd7;
  localparam logic [EXC_VEC_W-1:0] VEC_PRIV    = 8'd8;
  localparam logic [EXC_VEC_W-1:0] VEC_TRACE   = 8'd9;
  localparam logic [EXC_VEC_W-1:0] VEC_EMU_A   = 8'd10;
  localparam logic [EXC_VEC_W-1:0] VEC_EMU_F   = 8'd11;
  localparam logic [EXC_VEC_W-1:0] VEC_IRQ0    = 8'd24;
  localparam logic [EXC_VEC_W-1:0] VEC_TRAP0   = 8'd32;

  // lower rank = higher priority
  typedef enum logic [EXC_RANK_W-1:0] {
    RK_RESET, RK_BUS, RK_ALIGN, RK_TRACE, RK_IRQ, RK_ILLEGAL, RK_EMU_A,
    RK_EMU_F, RK_PRIV, RK_TRAP, RK_OVF, RK_BOUNDS, RK_DIVZ
  } exc_rank_e;

  typedef struct packed {
    logic                 valid;
    logic                 abort;
    exc_rank_e            rank;
    logic [EXC_VEC_W-1:0] vec;
  } exc_req_t;
endpackage

// File: rtl/exc_irq_gate.sv
module exc_irq_gate #(
  parameter int IPL_W = 3
) (
  input  logic [IPL_W-1:0] irq_n_i,
  input  logic [IPL_W-1:0] mask_i,
  output logic             req_o,
  output logic [IPL_W-1:0] level_o
);
  logic [IPL_W-1:0] level;

  assign level   = ~irq_n_i;
  assign level_o = level;
  // top level bypasses the mask
  assign req_o   = (|level) && ((level > mask_i) || (&level));
endmodule

// File: rtl/exc_pick.sv
module exc_pick
  import exc_pkg::*;
#(
  parameter int IPL_W  = 3,
  parameter int TRAP_W = 4,
  parameter int ADDR_W = EXC_VEC_W + 2
) (
  input  logic              reset_req_i,
  input  logic              bus_fault_i,
  input  logic              align_fault_i,
  input  logic              done_i,
  input  logic              trace_i,
  input  logic              irq_req_i,
  input  logic [IPL_W-1:0]  irq_level_i,
  input  logic              illegal_i,
  input  logic              emu_a_i,
  input  logic              emu_f_i,
  input  logic              priv_i,
  input  logic              trap_i,
  input  logic [TRAP_W-1:0] trap_num_i,
  input  logic              ovf_i,
  input  logic              bounds_i,
  input  logic              divz_i,
  output exc_req_t          cand_o,
  output logic [ADDR_W-1:0] addr_o
);
  exc_req_t c;

  always_comb begin
    c       = '0;
    c.valid = 1'b1;
    if (reset_req_i) begin
      c.abort = 1'b1; c.rank = RK_RESET; c.vec = VEC_RESET;
    end else if (bus_fault_i) begin
      c.abort = 1'b1; c.rank = RK_BUS; c.vec = VEC_BUS;
    end else if (align_fault_i) begin
      c.abort = 1'b1; c.rank = RK_ALIGN; c.vec = VEC_ALIGN;
    end else if (done_i && trace_i) begin
      c.rank = RK_TRACE; c.vec = VEC_TRACE;
    end else if (done_i && irq_req_i) begin
      c.rank = RK_IRQ; c.vec = VEC_IRQ0 + EXC_VEC_W'(irq_level_i);
    end else if (done_i && illegal_i) begin
      c.rank = RK_ILLEGAL; c.vec = VEC_ILLEGAL;
    end else if (done_i && emu_a_i) begin
      c.rank = RK_EMU_A; c.vec = VEC_EMU_A;
    end else if (done_i && emu_f_i) begin
      c.rank = RK_EMU_F; c.vec = VEC_EMU_F;
    end else if (done_i && priv_i) begin
      c.rank = RK_PRIV; c.vec = VEC_PRIV;
    end else if (trap_i) begin
      c.rank = RK_TRAP; c.vec = VEC_TRAP0 + EXC_VEC_W'(trap_num_i);
    end else if (ovf_i) begin
      c.rank = RK_OVF; c.vec = VEC_OVF;
    end else if (bounds_i) begin
      c.rank = RK_BOUNDS; c.vec = VEC_BOUNDS;
    end else if (divz_i) begin
      c.rank = RK_DIVZ; c.vec = VEC_DIVZ;
    end else begin
      c.valid = 1'b0;
    end
  end

  assign cand_o = c;
  assign addr_o = {c.vec, 2'b00};
endmodule

// File: rtl/exc_hold.sv
module exc_hold
  import exc_pkg::*;
#(
  parameter int ADDR_W = EXC_VEC_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  exc_req_t          cand_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              accept_i,
  output exc_req_t          req_o,
  output logic [ADDR_W-1:0] addr_o
);
  exc_req_t          q;
  logic [ADDR_W-1:0] a;
  logic              preempt;
  logic              load;

  // only a strictly higher fault may displace a held request
  assign preempt = cand_i.valid && cand_i.abort && (cand_i.rank < q.rank);
  assign load    = !q.valid || accept_i || preempt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q <= '0;
      a <= '0;
    end else if (load) begin
      q <= cand_i;
      a <= addr_i;
    end
  end

  assign req_o  = q;
  assign addr_o = a;

  // R9
  held_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q.valid && !accept_i && !(cand_i.valid && cand_i.abort))
      |=> (q.valid && $stable(q.vec)));

  // R10
  held_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q.valid && !accept_i) |=> (q.valid && ($stable(q.vec) || q.abort)));
endmodule

// File: rtl/exc_resolver.sv
module exc_resolver
  import exc_pkg::*;
#(
  parameter int IPL_W  = 3,
  parameter int TRAP_W = 4,
  parameter int VEC_W  = EXC_VEC_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 reset_req_i,
  input  logic                 bus_fault_i,
  input  logic                 align_fault_i,
  input  logic                 insn_done_i,
  input  logic                 sr_trace_i,
  input  logic [IPL_W-1:0]     irq_n_i,
  input  logic [IPL_W-1:0]     irq_mask_i,
  input  logic                 illegal_i,
  input  logic                 emu_a_i,
  input  logic                 emu_f_i,
  input  logic                 priv_viol_i,
  input  logic                 trap_i,
  input  logic [TRAP_W-1:0]    trap_num_i,
  input  logic                 ovf_trap_i,
  input  logic                 bounds_trap_i,
  input  logic                 div_zero_i,
  input  logic                 accept_i,
  output logic                 exc_valid_o,
  output logic [VEC_W-1:0]     exc_vec_o,
  output logic [VEC_W+1:0]     exc_addr_o,
  output logic                 exc_abort_o
);
  localparam int ADDR_W = VEC_W + 2;

  logic              irq_req;
  logic [IPL_W-1:0]  irq_level;
  exc_req_t          cand, held;
  logic [ADDR_W-1:0] cand_addr, held_addr;

  exc_irq_gate #(.IPL_W(IPL_W)) u_gate (
    .irq_n_i (irq_n_i),
    .mask_i  (irq_mask_i),
    .req_o   (irq_req),
    .level_o (irq_level)
  );

  exc_pick #(.IPL_W(IPL_W), .TRAP_W(TRAP_W), .ADDR_W(ADDR_W)) u_pick (
    .reset_req_i   (reset_req_i),
    .bus_fault_i   (bus_fault_i),
    .align_fault_i (align_fault_i),
    .done_i        (insn_done_i),
    .trace_i       (sr_trace_i),
    .irq_req_i     (irq_req),
    .irq_level_i   (irq_level),
    .illegal_i     (illegal_i),
    .emu_a_i       (emu_a_i),
    .emu_f_i       (emu_f_i),
    .priv_i        (priv_viol_i),
    .trap_i        (trap_i),
    .trap_num_i    (trap_num_i),
    .ovf_i         (ovf_trap_i),
    .bounds_i      (bounds_trap_i),
    .divz_i        (div_zero_i),
    .cand_o        (cand),
    .addr_o        (cand_addr)
  );

  exc_hold #(.ADDR_W(ADDR_W)) u_hold (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cand_i   (cand),
    .addr_i   (cand_addr),
    .accept_i (accept_i),
    .req_o    (held),
    .addr_o   (held_addr)
  );

  assign exc_valid_o = held.valid;
  assign exc_vec_o   = held.vec;
  assign exc_addr_o  = held_addr;
  assign exc_abort_o = held.abort;

  // R7
  addr_vec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_valid_o |-> (exc_addr_o == {exc_vec_o, 2'b00}));

  // R10
  abort_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_abort_o |-> (exc_vec_o == VEC_RESET || exc_vec_o == VEC_BUS ||
                     exc_vec_o == VEC_ALIGN));

  // R2
  bus_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_fault_i && !reset_req_i && (!exc_valid_o || accept_i))
      |=> (exc_vec_o == VEC_BUS && exc_abort_o));

  // R5
  nmi_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (insn_done_i && irq_n_i == '0 && !sr_trace_i && !reset_req_i &&
     !bus_fault_i && !align_fault_i && (!exc_valid_o || accept_i))
      |=> (exc_vec_o == VEC_IRQ0 + VEC_W'((1 << IPL_W) - 1)));

  // R3
  done_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!insn_done_i && (!exc_valid_o || accept_i))
      |=> !(exc_valid_o && ((exc_vec_o >= VEC_ILLEGAL + 8'd4 && exc_vec_o <= VEC_EMU_F) ||
                            exc_vec_o == VEC_ILLEGAL ||
                            (exc_vec_o > VEC_IRQ0 && exc_vec_o < VEC_TRAP0))));
endmodule

// File: tb/exc_resolver_test.sv
module exc_resolver_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reset_req, bus_f, align_f, done, trace;
  logic [2:0] irq_n, mask;
  logic       illegal, emu_a, emu_f, priv, trap;
  logic [3:0] trap_num;
  logic       ovf, bounds, divz, accept;
  logic       valid, abort;
  logic [7:0] vec;
  logic [9:0] addr;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_resolver uut (
    .clk_i(clk), .rst_ni(rst_n), .reset_req_i(reset_req), .bus_fault_i(bus_f),
    .align_fault_i(align_f), .insn_done_i(done), .sr_trace_i(trace),
    .irq_n_i(irq_n), .irq_mask_i(mask), .illegal_i(illegal), .emu_a_i(emu_a),
    .emu_f_i(emu_f), .priv_viol_i(priv), .trap_i(trap), .trap_num_i(trap_num),
    .ovf_trap_i(ovf), .bounds_trap_i(bounds), .div_zero_i(divz), .accept_i(accept),
    .exc_valid_o(valid), .exc_vec_o(vec), .exc_addr_o(addr), .exc_abort_o(abort)
  );

  // {valid, abort, addr, vec}
  function automatic logic [19:0] model();
    logic [2:0] lvl;
    logic       v, ab;
    logic [7:0] n;
    lvl = ~irq_n;
    v = 1'b1; ab = 1'b0; n = 8'd0;
    if (reset_req)                 begin ab = 1'b1; n = 8'd0; end
    else if (bus_f)                begin ab = 1'b1; n = 8'd2; end
    else if (align_f)              begin ab = 1'b1; n = 8'd3; end
    else if (done && trace)        n = 8'd9;
    else if (done && lvl != 0 && (lvl > mask || lvl == 3'd7)) n = 8'd24 + {5'd0, lvl};
    else if (done && illegal)      n = 8'd4;
    else if (done && emu_a)        n = 8'd10;
    else if (done && emu_f)        n = 8'd11;
    else if (done && priv)         n = 8'd8;
    else if (trap)                 n = 8'd32 + {4'd0, trap_num};
    else if (ovf)                  n = 8'd7;
    else if (bounds)               n = 8'd6;
    else if (divz)                 n = 8'd5;
    else v = 1'b0;
    if (!v) return 20'd0;
    return {v, ab, n, 2'b00, n};
  endfunction

  function automatic logic [19:0] obs();
    if (!valid) return {valid, abort, 18'd0};
    return {valid, abort, addr, vec};
  endfunction

  task automatic check(input string tag, input logic [19:0] got, input logic [19:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic clear();
    reset_req = 0; bus_f = 0; align_f = 0; done = 0; trace = 0;
    irq_n = 3'b111; mask = 0; illegal = 0; emu_a = 0; emu_f = 0; priv = 0;
    trap = 0; trap_num = 0; ovf = 0; bounds = 0; divz = 0;
  endtask

  task automatic tick();
    @(posedge clk);
    #(CLK_PERIOD/4);
  endtask

  function automatic logic [19:0] pack(input logic v, input logic ab, input logic [7:0] n);
    return {v, ab, n, 2'b00, n};
  endfunction

  logic [31:0] rs = 32'h1234_5679;
  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] t;
    t = s ^ (s << 13);
    t = t ^ (t >> 17);
    return t ^ (t << 5);
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    bad++;
    $display("FAIL watchdog got=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [19:0] e;
    clear();
    accept = 1'b1;
    #(CLK_PERIOD*2 + 1);
    // R1
    check("R1 in reset", obs(), 20'd0);
    @(negedge clk); rst_n = 1'b1;
    tick();
    check("R1 after release", obs(), 20'd0);

    // R8: not before the edge, right after it
    @(negedge clk); illegal = 1; done = 1;
    #1; check("R8 before edge", obs(), 20'd0);
    tick(); check("R8 after edge", obs(), pack(1, 0, 8'd4));
    clear();

    // R5 R3: interrupt level x mask x trace x done sweep
    for (int l = 0; l < 8; l++)
      for (int m = 0; m < 8; m++)
        for (int t = 0; t < 2; t++)
          for (int d = 0; d < 2; d++) begin
            irq_n = ~l[2:0]; mask = m[2:0]; trace = t[0]; done = d[0];
            divz = (l == 3);
            e = model();
            tick();
            check("R5 R3 sweep", obs(), e);
          end
    clear();

    // R2 faults without completion
    bus_f = 1; align_f = 1; trap = 1;
    tick(); check("R2 bus over align", obs(), pack(1, 1, 8'd2));
    bus_f = 0;
    tick(); check("R2 align", obs(), pack(1, 1, 8'd3));
    reset_req = 1;
    tick(); check("R2 reset", obs(), pack(1, 1, 8'd0));
    clear();

    // R6 group two order and all trap numbers
    for (int n = 0; n < 16; n++) begin
      trap = 1; trap_num = n[3:0]; ovf = 1; divz = 1;
      tick(); check("R6 trap number", obs(), pack(1, 0, 8'd32 + 8'(n)));
    end
    clear(); ovf = 1; bounds = 1; divz = 1;
    tick(); check("R6 overflow", obs(), pack(1, 0, 8'd7));
    ovf = 0;
    tick(); check("R6 bounds", obs(), pack(1, 0, 8'd6));
    bounds = 0;
    tick(); check("R6 divide zero", obs(), pack(1, 0, 8'd5));
    clear();

    // R4 completion order
    done = 1; emu_a = 1; emu_f = 1; priv = 1; trap = 1;
    tick(); check("R4 emu A", obs(), pack(1, 0, 8'd10));
    emu_a = 0;
    tick(); check("R4 emu F", obs(), pack(1, 0, 8'd11));
    emu_f = 0;
    tick(); check("R4 privilege", obs(), pack(1, 0, 8'd8));
    done = 0;
    tick(); check("R3 trap when not done", obs(), pack(1, 0, 8'd32));
    clear();

    // R4 R6 R7 random sparse sweep
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] a, b;
      rs = nxt(rs); a = rs;
      rs = nxt(rs); b = rs;
      reset_req = a[0] & a[1] & a[2] & a[3];
      bus_f = a[4] & a[5] & a[6];
      align_f = a[7] & a[8] & a[9];
      done = a[10];
      trace = a[11] & a[12];
      irq_n = a[15:13]; mask = a[18:16];
      illegal = a[19] & a[20];
      emu_a = a[21] & a[22];
      emu_f = a[23] & a[24];
      priv = a[25] & a[26];
      trap = b[0] & b[1];
      trap_num = b[5:2];
      ovf = b[6] & b[7];
      bounds = b[8] & b[9];
      divz = b[10] & b[11];
      e = model();
      tick();
      check("R4 R6 R7 random", obs(), e);
    end
    clear();
    tick();

    // R9 hold without accept
    accept = 0;
    done = 1; illegal = 1;
    tick(); check("R9 load", obs(), pack(1, 0, 8'd4));
    clear(); trap = 1; done = 1; trace = 1;
    tick(); check("R9 held 1", obs(), pack(1, 0, 8'd4));
    tick(); check("R9 held 2", obs(), pack(1, 0, 8'd4));
    clear();
    // R10 preempt by fault
    align_f = 1;
    tick(); check("R10 align preempts", obs(), pack(1, 1, 8'd3));
    align_f = 0; bus_f = 1;
    tick(); check("R10 bus preempts align", obs(), pack(1, 1, 8'd2));
    bus_f = 0; align_f = 1;
    tick(); check("R10 lower fault held off", obs(), pack(1, 1, 8'd2));
    clear(); reset_req = 1;
    tick(); check("R10 reset preempts", obs(), pack(1, 1, 8'd0));
    clear(); bus_f = 1;
    tick(); check("R10 reset kept", obs(), pack(1, 1, 8'd0));
    clear();
    // R9 accept loads current winner, then empties
    accept = 1; ovf = 1;
    tick(); check("R9 accept reload", obs(), pack(1, 0, 8'd7));
    clear();
    tick(); check("R9 accept empties", obs(), 20'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule